// File: doc/BRIEF.md
# Word-interleaved block-refill memory controller

The controller answers cache-block refill requests from a set of one-word-wide banks. A block holds as many words as there are banks. When a request is accepted, the block-aligned address is sent once to every bank over an address phase of configurable length. The banks then run their accesses side by side, and the words return one after another over a shared one-word bus. Each word takes a fixed transfer slot and is marked by a one-cycle valid pulse at the end of that slot.

A mode input, sampled when a request is accepted, switches to a non-interleaved comparison behaviour. In that mode every word goes through its own address phase, access and transfer in turn. With the default latencies (4-cycle address phase, 24-cycle access, 4-cycle transfer, 4 banks), an interleaved block finishes in 44 cycles and a non-interleaved block in 128.

Banks hold no stored contents. Each returns a word computed from its own word address, so a requester can check every word it receives.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, ready_o is 1 and rsp_valid_o and rsp_last_o are 0.
- R2: A block starts at the request address with its low log2(N_BANKS) bits cleared. Word i comes from bank i at word address base+i, and the words return in ascending i. The data of word address w is {~w, w}: the upper ADDR_W bits are the bitwise inverse of w and the lower ADDR_W bits are w.
- R3: In interleaved mode (mode_i=0 at acceptance), word i is valid in cycle T_ADDR+T_ACC+(i+1)*T_XFER after the accepting clock edge. With the defaults this is cycle 32 for word 0 and cycle 44 for the last word.
- R4: In non-interleaved mode (mode_i=1 at acceptance), word i is valid in cycle (i+1)*(T_ADDR+T_ACC+T_XFER). With the defaults the last word is in cycle 128.
- R5: rsp_valid_o is high for exactly one cycle per word and for no other cycle, so a block gives exactly N_BANKS pulses.
- R6: rsp_last_o is high only together with the valid pulse of the final word of a block.
- R7: ready_o is low from the cycle after acceptance through the final word's cycle. During that time, changes on req_i, addr_i and mode_i have no effect on the data or timing of the block being served.
- R8: ready_o is high again in the cycle after the final word. A request held there is accepted at the next clock edge, with no dead cycle.
- R9: The transfer mode is taken from mode_i at the accepting edge and holds for the whole block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Block read request; accepted on a clock edge while ready_o is high |
| addr_i | input | ADDR_W | Word address inside the requested block |
| mode_i | input | 1 | 0 = interleaved, 1 = non-interleaved, sampled at acceptance |
| ready_o | output | 1 | Controller idle and able to accept a request |
| rsp_valid_o | output | 1 | One-cycle pulse: rsp_data_o carries a word |
| rsp_last_o | output | 1 | Marks the final word of the block |
| rsp_data_o | output | 2*ADDR_W | Returned word |

## Verification
Every result has a fixed cycle number counted from the accepting edge. Word i is due in cycle T_ADDR+T_ACC+(i+1)*T_XFER when interleaved and in cycle (i+1)*(T_ADDR+T_ACC+T_XFER) when not. ready_o returns one cycle after the final word. The bench counts cycles from the acceptance edge and samples on the falling edge inside each numbered cycle. It expects a valid pulse exactly in the computed cycles and none in any other cycle, and it checks data and last at those points. While a block is running, the bench drives conflicting requests and a flipped mode, and then confirms that the words, timing and end of the block are unchanged.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACC,
    PH_XFER
  } phase_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ADDR_W = 16,
  parameter int T_ACC  = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  done_o,
  output logic [2*ADDR_W-1:0]   data_o
);
  localparam int CW = $clog2(T_ACC + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      addr_q <= addr_i;
      cnt_q  <= CW'(T_ACC - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // done in the last access cycle so the sequencer adds no extra cycle
  assign done_o = busy_q && (cnt_q == '0);
  assign data_o = {~addr_q, addr_q};
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int N_BANKS = 4,
  parameter int ADDR_W  = 16,
  parameter int T_ADDR  = 4,
  parameter int T_XFER  = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              mode_i,
  input  logic [N_BANKS-1:0]                bank_done_i,
  output logic                              ready_o,
  output logic [N_BANKS-1:0]                start_o,
  output logic [N_BANKS-1:0][ADDR_W-1:0]    bank_addr_o,
  output logic [$clog2(N_BANKS > 1 ? N_BANKS : 2)-1:0] sel_o,
  output logic                              valid_o,
  output logic                              last_o
);
  localparam int IW    = $clog2(N_BANKS > 1 ? N_BANKS : 2);
  localparam int T_MAX = (T_ADDR > T_XFER) ? T_ADDR : T_XFER;
  localparam int CW    = $clog2(T_MAX + 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(N_BANKS - 1);
  localparam logic [IW-1:0]     IDX_LAST   = IW'(N_BANKS - 1);

  phase_e            phase_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              serial_q;
  logic              acc_done;
  logic              addr_end;

  assign addr_end = (phase_q == PH_ADDR) && (cnt_q == '0);
  assign acc_done = serial_q ? bank_done_i[idx_q] : &bank_done_i;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank_ctl
    assign bank_addr_o[b] = base_q + ADDR_W'(b);
    assign start_o[b]     = addr_end && (!serial_q || (idx_q == IW'(b)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      base_q   <= '0;
      serial_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (req_i) begin
          base_q   <= addr_i & ALIGN_MASK;
          serial_q <= mode_i;
          idx_q    <= '0;
          cnt_q    <= CW'(T_ADDR - 1);
          phase_q  <= PH_ADDR;
        end
        PH_ADDR: begin
          if (cnt_q == '0) phase_q <= PH_ACC;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_ACC: if (acc_done) begin
          cnt_q   <= CW'(T_XFER - 1);
          phase_q <= PH_XFER;
        end
        PH_XFER: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (idx_q == IDX_LAST) begin
            phase_q <= PH_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (serial_q) begin
              cnt_q   <= CW'(T_ADDR - 1);
              phase_q <= PH_ADDR;
            end else begin
              cnt_q <= CW'(T_XFER - 1);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ready_o = (phase_q == PH_IDLE);
  assign valid_o = (phase_q == PH_XFER) && (cnt_q == '0);
  assign last_o  = valid_o && (idx_q == IDX_LAST);
  assign sel_o   = idx_q;
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int N_BANKS = 4,
  parameter int ADDR_W  = 16,
  parameter int T_ADDR  = 4,
  parameter int T_ACC   = 24,
  parameter int T_XFER  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  mode_i,
  output logic                  ready_o,
  output logic                  rsp_valid_o,
  output logic                  rsp_last_o,
  output logic [2*ADDR_W-1:0]   rsp_data_o
);
  localparam int DATA_W = 2 * ADDR_W;
  localparam int IW     = $clog2(N_BANKS > 1 ? N_BANKS : 2);

  logic [N_BANKS-1:0]              bank_done;
  logic [N_BANKS-1:0]              bank_start;
  logic [N_BANKS-1:0][ADDR_W-1:0]  bank_addr;
  logic [N_BANKS-1:0][DATA_W-1:0]  bank_data;
  logic [IW-1:0]                   sel;

  ilv_seq #(
    .N_BANKS (N_BANKS),
    .ADDR_W  (ADDR_W),
    .T_ADDR  (T_ADDR),
    .T_XFER  (T_XFER)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .mode_i      (mode_i),
    .bank_done_i (bank_done),
    .ready_o     (ready_o),
    .start_o     (bank_start),
    .bank_addr_o (bank_addr),
    .sel_o       (sel),
    .valid_o     (rsp_valid_o),
    .last_o      (rsp_last_o)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    ilv_bank #(
      .ADDR_W (ADDR_W),
      .T_ACC  (T_ACC)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (bank_start[b]),
      .addr_i  (bank_addr[b]),
      .done_o  (bank_done[b]),
      .data_o  (bank_data[b])
    );
  end

  // shared one-word return bus
  assign rsp_data_o = bank_data[sel];
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
  parameter int N_BANKS = 4,
  parameter int T_ADDR  = 4,
  parameter int T_ACC   = 24,
  parameter int T_XFER  = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic mode_i,
  input logic ready_o,
  input logic rsp_valid_o,
  input logic rsp_last_o
);
  localparam int LAT_ILV = T_ADDR + T_ACC + N_BANKS * T_XFER;
  localparam int LAT_SER = N_BANKS * (T_ADDR + T_ACC + T_XFER);

  int   cyc_q;
  int   beats_q;
  logic ser_q;
  logic accept;

  assign accept = req_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= 0;
      beats_q <= 0;
      ser_q   <= 1'b0;
    end else if (accept) begin
      cyc_q   <= 1;
      beats_q <= 0;
      ser_q   <= mode_i;
    end else begin
      if (!ready_o)    cyc_q   <= cyc_q + 1;
      if (rsp_valid_o) beats_q <= beats_q + 1;
    end
  end

  // R1 / R7: no response while idle
  a_r7_no_valid_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !ready_o);

  // R7: acceptance makes the controller busy
  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

  // R6
  a_r6_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> rsp_valid_o);

  // R5: exactly N_BANKS pulses per block
  a_r5_beat_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> (beats_q == N_BANKS - 1));

  // R3 / R4 / R9: block latency by mode latched at acceptance
  a_r3_r4_block_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> (cyc_q == (ser_q ? LAT_SER : LAT_ILV)));

  // R8
  a_r8_ready_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |=> ready_o);
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
  .N_BANKS (N_BANKS),
  .T_ADDR  (T_ADDR),
  .T_ACC   (T_ACC),
  .T_XFER  (T_XFER)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .mode_i      (mode_i),
  .ready_o     (ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_last_o  (rsp_last_o)
);

// File: tb/ilv_mem_ctrl_tb_top.sv
module ilv_mem_ctrl_tb_top;
  localparam int NB = 4;
  localparam int AW = 16;
  localparam int TA = 4;
  localparam int TC = 24;
  localparam int TX = 4;
  localparam int DW = 2 * AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          mode_i = 1'b0;
  logic          ready_o;
  logic          rsp_valid_o;
  logic          rsp_last_o;
  logic [DW-1:0] rsp_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  ilv_mem_ctrl #(
    .N_BANKS (NB), .ADDR_W (AW), .T_ADDR (TA), .T_ACC (TC), .T_XFER (TX)
  ) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .mode_i      (mode_i),
    .ready_o     (ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_last_o  (rsp_last_o),
    .rsp_data_o  (rsp_data_o)
  );

  function automatic int exp_cyc(int i, bit ser);
    return ser ? (i + 1) * (TA + TC + TX) : TA + TC + (i + 1) * TX;
  endfunction

  function automatic logic [DW-1:0] exp_data(logic [AW-1:0] w);
    return {~w, w};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // noise: conflicting request, address and mode while busy (R7, R9)
  task automatic run_block(logic [AW-1:0] addr, bit ser, bit noise);
    logic [AW-1:0] base;
    int last_c;
    int word;
    int stray;
    bit bad_ready;
    @(negedge clk_i);
    check(ready_o == 1'b1, "R8 ready before request", 64'(ready_o), 64'd1);
    req_i  = 1'b1;
    addr_i = addr;
    mode_i = ser;
    @(posedge clk_i);
    base      = addr & ~AW'(NB - 1);
    last_c    = exp_cyc(NB - 1, ser);
    word      = 0;
    stray     = 0;
    bad_ready = 1'b0;
    for (int c = 1; c <= last_c; c++) begin
      @(negedge clk_i);
      if (noise && c < last_c) begin
        req_i  = 1'b1;
        addr_i = AW'($urandom);
        mode_i = ~ser;
      end else begin
        req_i = 1'b0;
      end
      if (ready_o) bad_ready = 1'b1;
      if (word < NB && c == exp_cyc(word, ser)) begin
        check(rsp_valid_o == 1'b1, ser ? "R4 valid in due cycle" : "R3 valid in due cycle",
              64'(rsp_valid_o), 64'd1);
        check(rsp_data_o == exp_data(base + AW'(word)), "R2 word data/order",
              64'(rsp_data_o), 64'(exp_data(base + AW'(word))));
        check(rsp_last_o == (word == NB - 1), "R6 last flag",
              64'(rsp_last_o), 64'(word == NB - 1));
        word++;
      end else if (rsp_valid_o || rsp_last_o) begin
        stray++;
      end
    end
    check(stray == 0, "R5 no extra valid pulses", 64'(stray), 64'd0);
    check(!bad_ready, noise ? "R7 busy and inputs ignored (R9 mode held)" : "R7 busy until last",
          64'(bad_ready), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired, run hung");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    check(ready_o == 1'b1, "R1 ready after reset", 64'(ready_o), 64'd1);
    check(rsp_valid_o == 1'b0, "R1 valid low after reset", 64'(rsp_valid_o), 64'd0);
    check(rsp_last_o == 1'b0, "R1 last low after reset", 64'(rsp_last_o), 64'd0);
    rst_ni = 1'b1;
    // directed corners; consecutive calls are back-to-back (R8)
    run_block(16'h0000, 1'b0, 1'b0);
    run_block(16'hFFFF, 1'b0, 1'b1);
    run_block(16'h1237, 1'b1, 1'b0);
    run_block(16'h0002, 1'b1, 1'b1);
    run_block(16'h8001, 1'b0, 1'b1);
    // constrained random
    for (int k = 0; k < 40; k++) begin
      run_block(AW'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 5)) @(negedge clk_i);
    end
    @(negedge clk_i);
    check(ready_o == 1'b1, "R8 ready after final block", 64'(ready_o), 64'd1);
    summary();
    $finish;
  end
endmodule